// File: doc/BRIEF.md
# Cache Line Refill Controller

This block sits on the memory side of a cache and serves one miss at a time by bringing a four-word line across a clocked bus. It runs entirely on the bus clock. A requester presents a block address with a request strobe. The controller spends one cycle on the address. It then waits out the storage access time and hands the four words back on four output lanes, each lane with its own valid strobe. The last transfer carries a one-cycle done pulse.

A two-bit organisation input chooses how the backing storage is arranged, and each arrangement has its own exact timing:
- **Single-word path**: four separate accesses, each followed by one transfer beat.
- **Full-width path**: one access, then all four words in a single beat.
- **Four-bank interleave**: the four banks are accessed together, then the words are streamed out one per beat.

A miss-penalty meter counts the cycles of each refill and keeps the final count after done, so the cost of each arrangement can be read directly. The backing store is modelled as four small internal banks. Lane i always carries word i of the line, and word i always lives in bank i.

Top module: `refill_ctrl`

## Requirements
- R1: After reset, busy and done are 0, req_ready is 1, word_valid is 0 and penalty is 0.
- R2: A request is taken at a rising edge where req_valid and req_ready are both 1. Busy is then 1 from the next cycle through the done cycle. req_ready always equals the inverse of busy. A req_valid seen while busy starts nothing.
- R3: The first busy cycle is the address cycle, with word_valid 0. During the n-th cycle of a refill, penalty reads n.
- R4: With mode 0 (single-word path), word k (k = 0..3) is valid on lane k only, in refill cycle 17 + 16k. Done comes in cycle 65.
- R5: With mode 1 (full-width path), all four lanes are valid together in refill cycle 17, and done comes in that same cycle.
- R6: With mode 2 (interleaved banks), word k is valid on lane k only, in refill cycle 17 + k. Words arrive in ascending order and done comes in cycle 20.
- R7: Mode 3 gives exactly the timing and data of mode 0.
- R8: Whenever lane i is valid, its 32-bit word, at bits [32i+31:32i], equals 0x5A5A0000 + a·0x00010003 + i·0x11110000 (modulo 2^32), where a is the accepted block address.
- R9: Done is a single-cycle pulse that coincides with the last valid beat. Busy is 0 in the cycle after done. Penalty keeps its final value until the next request is taken.
- R10: Mode and block address are sampled only at acceptance. Changing them during a refill changes neither its timing nor its data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Refill request strobe |
| req_ready | output | 1 | High when a request can be taken |
| req_addr | input | 4 | Block address of the line to fetch |
| mode | input | 2 | Memory organisation: 0 single-word, 1 full-width, 2 interleaved, 3 as 0 |
| busy | output | 1 | Refill in progress |
| word_valid | output | 4 | Per-lane valid strobe, bit i for word i |
| word_data | output | 128 | Line words; lane i at bits [32i+31:32i] |
| done | output | 1 | One-cycle pulse with the final beat |
| penalty | output | 16 | Cycles spent by the current or last refill |

## Verification
Most internal faults show up within one cycle of the fault occurring. A slip in the access-wait count or the beat index shows as a valid strobe on the wrong cycle or lane. A wrongly latched organisation or address gives a different beat pattern or wrong data on the first transfer. A meter fault shows as a penalty value that differs from the refill cycle number. Because the bench model predicts busy, every lane strobe, done, penalty and lane data for every cycle, a fault is caught on the first cycle where any of these differ, and not only at the end of the refill. Explicit end-to-end latency checks confirm 65, 17 and 20 cycles.

// File: rtl/refill_pkg.sv
package refill_pkg;

    typedef enum logic [1:0] {
        ORG_NARROW = 2'd0,
        ORG_WIDE   = 2'd1,
        ORG_BANKED = 2'd2,
        ORG_ALIAS  = 2'd3
    } org_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_WAIT,
        PH_XFER
    } phase_e;

    // Content of a given row in a given bank of the modelled store.
    function automatic logic [31:0] store_word(input int unsigned row, input int unsigned bank);
        return 32'h5A5A_0000 + 32'(row) * 32'h0001_0003 + 32'(bank) * 32'h1111_0000;
    endfunction

endpackage

// File: rtl/refill_bank.sv
module refill_bank #(
    parameter int ADDR_W = 4,
    parameter int WORD_W = 32,
    parameter int BANK   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] row,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem_q [DEPTH];

    // Store is loaded with its known pattern on reset; there is no write path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < DEPTH; r++) begin
                mem_q[r] <= WORD_W'(refill_pkg::store_word(r, BANK));
            end
        end
    end

    assign rdata = mem_q[row];

endmodule

// File: rtl/refill_meter.sv
module refill_meter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CNT_W'(1);
        end else if (run && cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    AST_METER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !run) |=> $stable(cnt_q)) else $error("meter moved while idle"); // R9

endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl #(
    parameter int ADDR_W  = 4,
    parameter int WORD_W  = 32,
    parameter int LANES   = 4,
    parameter int ACC_CYC = 15,
    parameter int CNT_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [1:0]              mode,
    output logic                    busy,
    output logic [LANES-1:0]        word_valid,
    output logic [LANES*WORD_W-1:0] word_data,
    output logic                    done,
    output logic [CNT_W-1:0]        penalty
);
    import refill_pkg::*;

    localparam int WAIT_W     = $clog2(ACC_CYC + 1);
    localparam int IDX_W      = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int LAT_NARROW = 1 + LANES * (ACC_CYC + 1);
    localparam int LAT_WIDE   = ACC_CYC + 2;
    localparam int LAT_BANKED = ACC_CYC + 1 + LANES;

    typedef struct packed {
        phase_e            ph;
        org_e              org;
        logic [ADDR_W-1:0] row;
        logic [WAIT_W-1:0] wt;
        logic [IDX_W-1:0]  idx;
    } state_t;

    state_t s_d, s_q;
    logic   accept;
    logic   xfer;
    logic   last_beat;

    always_comb begin
        s_d    = s_q;
        accept = req_valid && (s_q.ph == PH_IDLE);
        unique case (s_q.ph)
            PH_IDLE: begin
                if (accept) begin
                    s_d.ph  = PH_ADDR;
                    s_d.org = (org_e'(mode) == ORG_ALIAS) ? ORG_NARROW : org_e'(mode);
                    s_d.row = req_addr;
                    s_d.wt  = '0;
                    s_d.idx = '0;
                end
            end
            PH_ADDR: begin
                s_d.ph = PH_WAIT;
                s_d.wt = '0;
            end
            PH_WAIT: begin
                if (s_q.wt == WAIT_W'(ACC_CYC - 1)) s_d.ph = PH_XFER;
                else                               s_d.wt = s_q.wt + WAIT_W'(1);
            end
            PH_XFER: begin
                if (s_q.org == ORG_WIDE || s_q.idx == IDX_W'(LANES - 1)) begin
                    s_d.ph = PH_IDLE;
                end else begin
                    s_d.idx = s_q.idx + IDX_W'(1);
                    s_d.wt  = '0;
                    if (s_q.org == ORG_NARROW) s_d.ph = PH_WAIT;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ph  <= PH_IDLE;
            s_q.org <= ORG_NARROW;
            s_q.row <= '0;
            s_q.wt  <= '0;
            s_q.idx <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign xfer      = (s_q.ph == PH_XFER);
    assign last_beat = xfer && (s_q.org == ORG_WIDE || s_q.idx == IDX_W'(LANES - 1));
    assign busy      = (s_q.ph != PH_IDLE);
    assign req_ready = !busy;
    assign done      = last_beat;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [WORD_W-1:0] bank_word;
        refill_bank #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BANK(b)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .row   (s_q.row),
            .rdata (bank_word)
        );
        assign word_valid[b] = xfer && (s_q.org == ORG_WIDE || s_q.idx == IDX_W'(b));
        assign word_data[b*WORD_W +: WORD_W] = bank_word;
    end

    refill_meter #(.CNT_W(CNT_W)) u_meter (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .run   (busy && !last_beat),
        .count (penalty)
    );

    AST_START_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy && penalty == CNT_W'(1))) else $error("start"); // R3
    AST_NO_DATA_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (word_valid == '0)) else $error("data in address cycle"); // R3
    AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (|word_valid) |-> busy) else $error("valid while idle"); // R2
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy) else $error("busy after done"); // R9
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (penalty == CNT_W'(LAT_NARROW) || penalty == CNT_W'(LAT_WIDE)
                  || penalty == CNT_W'(LAT_BANKED))) else $error("latency"); // R4
    AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(word_valid) > 1) |-> (word_valid == '1 && done)) else $error("lanes"); // R6
    AST_IDLE_PENALTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid) |=> $stable(penalty)) else $error("penalty drift"); // R9

endmodule

// File: tb/sim_refill_ctrl.sv
`timescale 1ns/1ps
module sim_refill_ctrl;
    localparam int ACC = 15;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [3:0]   req_addr = '0;
    logic [1:0]   mode = '0;
    logic         busy;
    logic [3:0]   word_valid;
    logic [127:0] word_data;
    logic         done;
    logic [15:0]  penalty;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    refill_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .mode(mode), .busy(busy), .word_valid(word_valid),
        .word_data(word_data), .done(done), .penalty(penalty)
    );

    // ---------------- behavioural reference ----------------
    bit m_busy = 0;
    int m_cyc = 0;
    int m_org = 0;
    int m_row = 0;
    int m_pen = 0;
    bit m_alias = 0;

    function automatic int span(input int org);
        if (org == 1) return ACC + 2;
        if (org == 2) return ACC + 5;
        return 1 + 4 * (ACC + 1);
    endfunction

    function automatic logic [3:0] lanes_at(input int org, input int cyc);
        logic [3:0] v = '0;
        int rel = cyc - (ACC + 2);
        if (org == 1) begin
            if (rel == 0) v = 4'hF;
        end else if (org == 2) begin
            if (rel >= 0 && rel < 4) v[rel] = 1'b1;
        end else begin
            if (rel >= 0 && rel % (ACC + 1) == 0 && rel / (ACC + 1) < 4) v[rel / (ACC + 1)] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic [31:0] line_word(input int a, input int i);
        return 32'h5A5A_0000 + 32'(a) * 32'h0001_0003 + 32'(i) * 32'h1111_0000;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_cyc = 0; m_pen = 0;
        end else if (m_busy) begin
            if (m_cyc == span(m_org)) m_busy = 0;
            else begin m_cyc++; m_pen = m_cyc; end
        end else if (req_valid) begin
            m_busy = 1; m_cyc = 1; m_pen = 1;
            m_alias = (mode == 2'd3);
            m_org = (mode == 2'd3) ? 0 : int'(mode);
            m_row = int'(req_addr);
        end
    end

    function automatic string org_tag();
        if (m_org == 1) return "R5";
        if (m_org == 2) return "R6";
        return m_alias ? "R7" : "R4";
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] ev;
            ev = m_busy ? lanes_at(m_org, m_cyc) : 4'h0;
            check("R2 busy", 128'(busy), 128'(m_busy));
            check("R2 ready", 128'(req_ready), 128'(!m_busy));
            check({org_tag(), " lanes"}, 128'(word_valid), 128'(ev));
            check("R9 done", 128'(done), 128'(m_busy && m_cyc == span(m_org)));
            check("R3 penalty", 128'(penalty), 128'(m_pen));
            for (int i = 0; i < 4; i++) begin
                if (ev[i]) check("R8 data", 128'(word_data[i*32 +: 32]), 128'(line_word(m_row, i)));
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic refill(input logic [1:0] md, input logic [3:0] a, input int exp_n,
                          input string tag, input bit perturb);
        int n;
        @(negedge clk);
        req_valid = 1'b1; mode = md; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
            if (perturb) begin mode = ~md; req_addr = ~a; end
        end
        check(tag, 128'(n), 128'(exp_n));
        @(negedge clk);
        check("R9 busy after done", 128'(busy), 128'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", 128'(busy), 128'(0));
        check("R1 ready", 128'(req_ready), 128'(1));
        check("R1 valid", 128'(word_valid), 128'(0));
        check("R1 done", 128'(done), 128'(0));
        check("R1 penalty", 128'(penalty), 128'(0));
        rst_n = 1'b1;

        refill(2'd0, 4'd3, 65, "R4 latency", 0);
        refill(2'd1, 4'd15, 17, "R5 latency", 0);
        refill(2'd2, 4'd7, 20, "R6 latency", 0);
        refill(2'd3, 4'd0, 65, "R7 latency", 0);
        refill(2'd2, 4'd9, 20, "R10 latency", 1);
        refill(2'd1, 4'd4, 17, "R10 latency", 1);

        // Requests while busy must be ignored (R2)
        @(negedge clk);
        req_valid = 1'b1; mode = 2'd0; req_addr = 4'd5;
        @(negedge clk);
        mode = 2'd1; req_addr = 4'd2;
        repeat (10) @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        repeat (5) @(negedge clk);
        check("R2 idle after ignored requests", 128'(busy), 128'(0));
        check("R9 penalty held", 128'(penalty), 128'(65));

        // Held request: back-to-back refills with one idle cycle between (R2)
        @(negedge clk);
        req_valid = 1'b1; mode = 2'd2; req_addr = 4'd11;
        repeat (45) @(negedge clk);
        req_valid = 1'b0;
        repeat (25) @(negedge clk);
        check("R2 held request done", 128'(busy), 128'(0));

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule